// File: doc/BRIEF.md
# Indirect Pointer Update Unit

This block holds two 16-bit indirect-access pointers and decodes the compiler-oriented instructions that use them. For each instruction it works out the data-memory address to access and the new pointer value, and it raises a flag when the access needs one more instruction cycle. The instructions it handles add a signed literal to a pointer, load or store through a pointer with automatic pre/post increment or decrement, and load or store at a pointer plus a signed offset. The data memory, the ALU and the program counter live outside the block.

A 14-bit instruction is presented on `insn` together with `insn_vld`. Every output for that instruction is combinational in the same cycle. The selected pointer register takes its new value on the next rising clock edge. A load raises `mem_rd` and `z_update`, so the surrounding core knows to set the zero flag from the fetched byte. A store raises `mem_wr` and leaves the flags alone.

Top module: `fsr_ptr_unit`

## Requirements
- R1: After a synchronous active-low reset, both pointers read 0x0000 and no access strobe or write-back is asserted while no instruction is valid.
- R2: The literal-add form `11 0001 0 n kkkkkk` (insn[13:7]=7'b1100010, n=insn[6], k=insn[5:0]) adds k, sign-extended from 6 bits, to the pointer selected by n. It raises neither access strobe and never asks for an extra cycle.
- R3: The auto-modify load is `insn[13:3]=11'b00000000010` and the auto-modify store is `insn[13:3]=11'b00000000011`. In both, n=insn[2] and the modifier m=insn[1:0]. For a pre-modify form (m[1]=0), the access address is the updated pointer.
- R4: For a post-modify form (m[1]=1), the access address is the old pointer. The pointer still takes its updated value at the next edge.
- R5: Modifier bit m[0]=0 steps the pointer by +1 and m[0]=1 steps it by -1. So 00 is pre-increment, 01 pre-decrement, 10 post-increment and 11 post-decrement.
- R6: The indexed load is `insn[13:7]=7'b1111110` and the indexed store is `insn[13:7]=7'b1111111`, with n=insn[6] and k=insn[5:0]. They access pointer + sign-extended k and never change any pointer.
- R7: Loads (auto-modify and indexed) assert `mem_rd` and `z_update`. Stores assert `mem_wr` only. The two strobes are never active together.
- R8: `extra_cycle` is 1 exactly when an access is made and bit 15 of its address is set.
- R9: All pointer and address arithmetic wraps modulo 2^16.
- R10: With `insn_vld` low, or with any other instruction code, no strobe or write-back is asserted and both pointers hold.
- R11: Only the pointer selected by n changes. The other pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_vld | input | 1 | Instruction on `insn` is to be executed this cycle |
| insn | input | 14 | Instruction word |
| mem_rd | output | 1 | Load access this cycle |
| mem_wr | output | 1 | Store access this cycle |
| mem_addr | output | 16 | Access address, valid while a strobe is high |
| z_update | output | 1 | Zero flag must be updated from the loaded byte |
| extra_cycle | output | 1 | Access needs one additional instruction cycle |
| ptr_we | output | 1 | A pointer is written at the next edge |
| ptr_sel | output | 1 | Which pointer is written (0 or 1) |
| ptr_next | output | 16 | Value the selected pointer takes |
| fsr0_q | output | 16 | Current value of pointer 0 |
| fsr1_q | output | 16 | Current value of pointer 1 |

## Verification
If a pointer register drifts or a write lands on the wrong pointer, the fault shows on `fsr0_q`/`fsr1_q` one edge after the faulty instruction. It also shows in the `mem_addr` of the next access through that pointer, in the same cycle that access is presented. If pre- and post-modify are swapped, or the step direction is inverted, `mem_addr` is wrong within the same cycle. If the sign extension is wrong, the damage appears only for negative literals, so the stimulus includes negative literals and wrap-around across 0x0000/0xFFFF. A misplaced extra-cycle decision appears only when an access address crosses into the upper half.

// File: rtl/fsr_pkg.sv
// Package: shared types and constants of the indirect pointer unit.
// Assumes a 14-bit instruction word and two pointers selected by one bit.
package fsr_pkg;

    localparam int INSN_W = 14;
    localparam int LIT_W  = 6;

    // Operation classes recognised by the decoder
    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_ADDK    = 3'd1,
        OP_AUTO_LD = 3'd2,
        OP_AUTO_ST = 3'd3,
        OP_IDX_LD  = 3'd4,
        OP_IDX_ST  = 3'd5
    } op_kind_e;

    // Decoded instruction fields
    typedef struct packed {
        op_kind_e           kind;
        logic               sel;
        logic [1:0]         mod;
        logic [LIT_W-1:0]   lit;
    } dec_t;

    // Opcode prefixes
    localparam logic [6:0]  PFX_ADDK   = 7'b1100010;
    localparam logic [6:0]  PFX_IDX_LD = 7'b1111110;
    localparam logic [6:0]  PFX_IDX_ST = 7'b1111111;
    localparam logic [10:0] PFX_AUTO_LD = 11'b00000000010;
    localparam logic [10:0] PFX_AUTO_ST = 11'b00000000011;

endpackage

// File: rtl/fsr_decode.sv
// Module: fsr_decode
// Classifies an instruction word into one of the pointer operations and
// extracts the pointer select, modifier and literal fields.
// Assumes: any code not listed decodes to OP_NONE; an invalid cycle is OP_NONE.
module fsr_decode
    import fsr_pkg::*;
(
    input  logic              vld,
    input  logic [INSN_W-1:0] insn,
    output dec_t              dec
);

    logic [6:0]  pfx7;
    logic [10:0] pfx11;

    assign pfx7  = insn[13:7];
    assign pfx11 = insn[13:3];

    // Pattern match the prefixes and pick the field layout that goes with them
    always_comb begin
        dec.kind = OP_NONE;
        dec.sel  = 1'b0;
        dec.mod  = 2'b00;
        dec.lit  = '0;
        if (vld) begin
            if (pfx11 == PFX_AUTO_LD || pfx11 == PFX_AUTO_ST) begin
                dec.kind = (pfx11 == PFX_AUTO_LD) ? OP_AUTO_LD : OP_AUTO_ST;
                dec.sel  = insn[2];
                dec.mod  = insn[1:0];
            end else if (pfx7 == PFX_ADDK) begin
                dec.kind = OP_ADDK;
                dec.sel  = insn[6];
                dec.lit  = insn[LIT_W-1:0];
            end else if (pfx7 == PFX_IDX_LD) begin
                dec.kind = OP_IDX_LD;
                dec.sel  = insn[6];
                dec.lit  = insn[LIT_W-1:0];
            end else if (pfx7 == PFX_IDX_ST) begin
                dec.kind = OP_IDX_ST;
                dec.sel  = insn[6];
                dec.lit  = insn[LIT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/fsr_addr_calc.sv
// Module: fsr_addr_calc
// Computes the access address, the updated pointer value, the strobes and
// the extra-cycle flag for one decoded operation on one base pointer.
// Assumes: arithmetic wraps at PTR_W bits; literal is signed LIT_W bits.
module fsr_addr_calc
    import fsr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  dec_t             dec,
    input  logic [PTR_W-1:0] base,
    output logic [PTR_W-1:0] ea,
    output logic [PTR_W-1:0] next,
    output logic             we,
    output logic             rd,
    output logic             wr,
    output logic             slow
);

    localparam int EXT_W = PTR_W - LIT_W;

    logic [PTR_W-1:0] lit_sx;
    logic [PTR_W-1:0] step;
    logic [PTR_W-1:0] bumped;
    logic [PTR_W-1:0] offset;

    assign lit_sx = {{EXT_W{dec.lit[LIT_W-1]}}, dec.lit};
    assign step   = dec.mod[0] ? {PTR_W{1'b1}} : PTR_W'(1);
    assign bumped = base + step;
    assign offset = base + lit_sx;

    // Select address, write-back value and strobes per operation class
    always_comb begin
        ea   = base;
        next = base;
        we   = 1'b0;
        rd   = 1'b0;
        wr   = 1'b0;
        unique case (dec.kind)
            OP_ADDK: begin
                next = offset;
                we   = 1'b1;
            end
            OP_AUTO_LD, OP_AUTO_ST: begin
                next = bumped;
                we   = 1'b1;
                ea   = dec.mod[1] ? base : bumped;
                rd   = (dec.kind == OP_AUTO_LD);
                wr   = (dec.kind == OP_AUTO_ST);
            end
            OP_IDX_LD, OP_IDX_ST: begin
                ea   = offset;
                rd   = (dec.kind == OP_IDX_LD);
                wr   = (dec.kind == OP_IDX_ST);
            end
            default: begin
                ea = base;
            end
        endcase
    end

    // Upper-half accesses cost one more instruction cycle
    assign slow = (rd | wr) & ea[PTR_W-1];

endmodule

// File: rtl/fsr_bank.sv
// Module: fsr_bank
// Holds NUM_PTR pointer registers; writes the selected one when enabled.
// Assumes: synchronous active-low reset clears every pointer to zero.
module fsr_bank #(
    parameter int PTR_W   = 16,
    parameter int NUM_PTR = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [SEL_W-1:0]         sel,
    input  logic [PTR_W-1:0]         wdata,
    output logic [NUM_PTR*PTR_W-1:0] q_flat
);

    localparam int SEL_W = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        logic [PTR_W-1:0] q;
        // Pointer register i: reset to zero, load on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && sel == SEL_W'(i)) begin
                q <= wdata;
            end
        end
        assign q_flat[i*PTR_W +: PTR_W] = q;
    end

endmodule

// File: rtl/fsr_ptr_unit.sv
// Module: fsr_ptr_unit (top)
// Decodes pointer instructions, computes access address and pointer update,
// and holds the two pointers. Outputs refer to the instruction on insn now;
// the pointer changes on the next rising edge.
// Assumes: insn_vld qualifies insn; memory, ALU and PC are external.
module fsr_ptr_unit
    import fsr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_vld,
    input  logic [INSN_W-1:0] insn,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [PTR_W-1:0]  mem_addr,
    output logic              z_update,
    output logic              extra_cycle,
    output logic              ptr_we,
    output logic              ptr_sel,
    output logic [PTR_W-1:0]  ptr_next,
    output logic [PTR_W-1:0]  fsr0_q,
    output logic [PTR_W-1:0]  fsr1_q
);

    localparam int NUM_PTR = 2;

    dec_t                     dec;
    logic [PTR_W-1:0]         base;
    logic [NUM_PTR*PTR_W-1:0] bank_q;

    fsr_decode u_dec (
        .vld  (insn_vld),
        .insn (insn),
        .dec  (dec)
    );

    assign fsr0_q = bank_q[0 +: PTR_W];
    assign fsr1_q = bank_q[PTR_W +: PTR_W];

    // Pick the pointer named by the instruction
    assign base = dec.sel ? fsr1_q : fsr0_q;

    fsr_addr_calc #(.PTR_W(PTR_W)) u_calc (
        .dec  (dec),
        .base (base),
        .ea   (mem_addr),
        .next (ptr_next),
        .we   (ptr_we),
        .rd   (mem_rd),
        .wr   (mem_wr),
        .slow (extra_cycle)
    );

    assign ptr_sel  = dec.sel;
    assign z_update = mem_rd;

    fsr_bank #(.PTR_W(PTR_W), .NUM_PTR(NUM_PTR)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ptr_we),
        .sel    (ptr_sel),
        .wdata  (ptr_next),
        .q_flat (bank_q)
    );

endmodule

// File: rtl/fsr_ptr_unit_chk.sv
// Module: fsr_ptr_unit_chk
// Checker bound to fsr_ptr_unit; observes ports only.
module fsr_ptr_unit_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             insn_vld,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [PTR_W-1:0] mem_addr,
    input logic             z_update,
    input logic             extra_cycle,
    input logic             ptr_we,
    input logic             ptr_sel,
    input logic [PTR_W-1:0] ptr_next,
    input logic [PTR_W-1:0] fsr0_q,
    input logic [PTR_W-1:0] fsr1_q
);

    assert_rd_wr_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_store_no_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !z_update);

    assert_slow_upper_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        extra_cycle |-> ((mem_rd || mem_wr) && mem_addr[PTR_W-1]));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld |-> (!mem_rd && !mem_wr && !ptr_we));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld |=> ($stable(fsr0_q) && $stable(fsr1_q)));

    assert_write_ptr0_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && !ptr_sel) |=> (fsr0_q == $past(ptr_next) && $stable(fsr1_q)));

    assert_write_ptr1_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we && ptr_sel) |=> (fsr1_q == $past(ptr_next) && $stable(fsr0_q)));

endmodule

bind fsr_ptr_unit fsr_ptr_unit_chk #(.PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .insn_vld    (insn_vld),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_addr    (mem_addr),
    .z_update    (z_update),
    .extra_cycle (extra_cycle),
    .ptr_we      (ptr_we),
    .ptr_sel     (ptr_sel),
    .ptr_next    (ptr_next),
    .fsr0_q      (fsr0_q),
    .fsr1_q      (fsr1_q)
);

// File: tb/fsr_ptr_unit_test.sv
// Bench for fsr_ptr_unit: vector table walked from reset, then directed tests.
module fsr_ptr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_vld = 1'b0;
    logic [13:0] insn = '0;
    logic        mem_rd, mem_wr, z_update, extra_cycle, ptr_we, ptr_sel;
    logic [15:0] mem_addr, ptr_next, fsr0_q, fsr1_q;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fsr_ptr_unit uut (
        .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .insn(insn),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .z_update(z_update), .extra_cycle(extra_cycle), .ptr_we(ptr_we),
        .ptr_sel(ptr_sel), .ptr_next(ptr_next), .fsr0_q(fsr0_q), .fsr1_q(fsr1_q)
    );

    // Fields: req id, insn, rd, wr, addr, slow, fsr0 after, fsr1 after
    localparam int NV = 17;
    localparam logic [72:0] VEC [NV] = '{
        {8'd2,  14'h311F, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h001F, 16'h0000}, // R2 +31 on ptr0
        {8'd2,  14'h3160, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h001F, 16'hFFE0}, // R2 -32 on ptr1
        {8'd3,  14'h0010, 1'b1, 1'b0, 16'h0020, 1'b0, 16'h0020, 16'hFFE0}, // R3 pre-inc load
        {8'd4,  14'h0012, 1'b1, 1'b0, 16'h0020, 1'b0, 16'h0021, 16'hFFE0}, // R4 post-inc load
        {8'd5,  14'h0019, 1'b0, 1'b1, 16'h0020, 1'b0, 16'h0020, 16'hFFE0}, // R5 pre-dec store
        {8'd5,  14'h001B, 1'b0, 1'b1, 16'h0020, 1'b0, 16'h001F, 16'hFFE0}, // R5 post-dec store
        {8'd8,  14'h0014, 1'b1, 1'b0, 16'hFFE1, 1'b1, 16'h001F, 16'hFFE1}, // R8 upper half
        {8'd6,  14'h3F05, 1'b1, 1'b0, 16'h0024, 1'b0, 16'h001F, 16'hFFE1}, // R6 idx load +5
        {8'd6,  14'h3FFF, 1'b0, 1'b1, 16'hFFE0, 1'b1, 16'h001F, 16'hFFE1}, // R6 idx store -1
        {8'd9,  14'h3F20, 1'b1, 1'b0, 16'hFFFF, 1'b1, 16'h001F, 16'hFFE1}, // R9 idx wrap below 0
        {8'd9,  14'h315F, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h001F, 16'h0000}, // R9 add wraps to 0
        {8'd9,  14'h001D, 1'b0, 1'b1, 16'hFFFF, 1'b1, 16'h001F, 16'hFFFF}, // R9 pre-dec wraps
        {8'd4,  14'h0016, 1'b1, 1'b0, 16'hFFFF, 1'b1, 16'h001F, 16'h0000}, // R4 post-inc wraps
        {8'd10, 14'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h001F, 16'h0000}, // R10 other code
        {8'd10, 14'h3180, 1'b0, 1'b0, 16'h0000, 1'b0, 16'h001F, 16'h0000}, // R10 near-miss add
        {8'd8,  14'h0017, 1'b1, 1'b0, 16'h0000, 1'b0, 16'h001F, 16'hFFFF}, // R8 post-dec, ea low
        {8'd11, 14'h0011, 1'b1, 1'b0, 16'h001E, 1'b0, 16'h001E, 16'hFFFF}  // R11 ptr1 untouched
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        string rq;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "fsr0", fsr0_q, 16'h0000);
        check("R1", "fsr1", fsr1_q, 16'h0000);
        check("R1", "strobes", {14'd0, mem_rd, mem_wr}, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rq = $sformatf("R%0d", VEC[i][72:65]);
            insn_vld = 1'b1;
            insn = VEC[i][64:51];
            #1;
            check(rq, "mem_rd", {15'd0, mem_rd}, {15'd0, VEC[i][50]});
            check(rq, "mem_wr", {15'd0, mem_wr}, {15'd0, VEC[i][49]});
            check(rq, "z_update (R7)", {15'd0, z_update}, {15'd0, VEC[i][50]});
            if (VEC[i][50] | VEC[i][49])
                check(rq, "mem_addr", mem_addr, VEC[i][48:33]);
            check(rq, "extra_cycle", {15'd0, extra_cycle}, {15'd0, VEC[i][32]});
            @(posedge clk);
            #1;
            check(rq, "fsr0 after", fsr0_q, VEC[i][31:16]);
            check(rq, "fsr1 after", fsr1_q, VEC[i][15:0]);
        end

        // R10: an access instruction with insn_vld low does nothing
        @(negedge clk);
        insn_vld = 1'b0;
        insn = 14'h0010;
        #1;
        check("R10", "strobes idle", {14'd0, mem_rd, mem_wr}, 16'h0);
        check("R10", "ptr_we idle", {15'd0, ptr_we}, 16'h0);
        @(posedge clk);
        #1;
        check("R10", "fsr0 hold", fsr0_q, 16'h001E);
        check("R10", "fsr1 hold", fsr1_q, 16'hFFFF);

        // R7: a load raises z_update, a store does not
        @(negedge clk);
        insn_vld = 1'b1;
        insn = 14'h3F80;
        #1;
        check("R7", "store z_update", {15'd0, z_update}, 16'h0);
        check("R7", "store addr", mem_addr, 16'h001E);

        // R1: reset mid-run clears both pointers
        @(negedge clk);
        insn_vld = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "fsr0 re-reset", fsr0_q, 16'h0000);
        check("R1", "fsr1 re-reset", fsr1_q, 16'h0000);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule